// File: doc/BRIEF.md
# Periodic Comparator Timer Channel

This block is a single timer channel. It watches a free-running main counter that arrives on an input and compares it with a comparator register that the channel holds. When the counter reaches or passes the comparator, the channel raises a one-cycle interrupt pulse. The channel has two modes. In one-shot mode it fires once for each expiry. In periodic mode it also holds a period register. After each expiry it steps the comparator forward by one period per clock cycle until the comparator lies ahead of the counter again.

Software sets the channel up through a small configuration register and a comparator write port. The configuration register holds these fields: level-trigger select (bit 1), timer enable (bit 2), periodic mode (bit 3), set-value (bit 6) and narrow mode (bit 8). In narrow mode the channel works on the low half of the counter width. Every other configuration bit reads as zero. The set-value bit makes the next comparator write in periodic mode go to the comparator instead of the period register, and it clears itself when that write is accepted.

The comparator write port is a valid/ready stream. A write is accepted on a clock edge where `cmp_wr_valid` and `cmp_wr_ready` are both high. `cmp_wr_ready` drops while the channel is stepping the comparator after a periodic expiry. The writer must then hold its valid and data stable until ready returns. Configuration writes are plain single-cycle strobes and are never stalled.

Top module: `tmr_chan`

## Requirements
- R1: After reset the comparator reads all ones, the configuration reads zero, `irq` and `lvl_err` are low, and `cmp_wr_ready` is high.
- R2: An accepted comparator write loads the comparator directly when periodic mode (bit 3) is clear or set-value (bit 6) is set. Every accepted comparator write clears set-value.
- R3: In periodic mode with set-value clear, an accepted write loads the period instead. A value below MIN_PER is first raised to MIN_PER. The most significant bit of the active width is then cleared.
- R4: In narrow mode (bit 8), written values are truncated to the low half width, and writing bit 8 as one also truncates the stored comparator and period. Expiry then uses the wrap-aware signed difference of the low halves.
- R5: Expiry is the signed difference (counter − comparator) being non-negative at the active width. The rising of that condition gives exactly one `irq` pulse, visible one cycle after the counter value that caused it. Accepting a direct comparator write re-arms detection.
- R6: On a periodic expiry with a nonzero period, the comparator ends as the smallest value comparator + k·period (k ≥ 1, wrapping at the active width) that lies strictly after the counter. With a zero period the comparator is left unchanged.
- R7: With `glb_en` low the channel neither fires nor advances. With timer enable (bit 2) low, the comparator still advances but no `irq` is raised.
- R8: `lvl_err` is high exactly while the level-trigger select (bit 1) is set.
- R9: `cmp_wr_ready` is low while the comparator is being advanced. A write presented in that time takes effect only once ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global enable for expiry handling |
| cnt_in | input | CNT_W | Main counter value |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| cmp_wr_valid | input | 1 | Comparator write valid |
| cmp_wr_ready | output | 1 | Comparator write ready |
| cmp_wr_data | input | CNT_W | Comparator write data |
| cmp_rdata | output | CNT_W | Comparator readback |
| irq | output | 1 | Single-cycle edge interrupt |
| lvl_err | output | 1 | Unsupported level-trigger selected |

## Verification
The bench builds the channel with a 16-bit counter and MIN_PER = 5, so narrow mode works on 8 bits. At this size the sweeps are close to exhaustive. Every possible narrow period write (0 to 255) is tried, including the values where the top-bit mask pulls the period below the minimum or down to zero. Comparator positions and counter jumps are swept across many advance counts, and the counter is run through the 8-bit wrap, so every signed-difference sign case is reached in a few thousand cycles.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  localparam int CFG_W = 16;
  localparam int B_LVL = 1;
  localparam int B_EN  = 2;
  localparam int B_PER = 3;
  localparam int B_SV  = 6;
  localparam int B_NAR = 8;

  function automatic logic [CFG_W-1:0] cfg_wmask();
    logic [CFG_W-1:0] m;
    m = '0;
    m[B_LVL] = 1'b1;
    m[B_EN]  = 1'b1;
    m[B_PER] = 1'b1;
    m[B_SV]  = 1'b1;
    m[B_NAR] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
  import tmr_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             clr_sv,
  output logic [CFG_W-1:0] cfg_q
);
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr) cfg_d = wdata & cfg_wmask();
    // an accepted comparator write wins over a same-cycle set-value write
    if (clr_sv) cfg_d[B_SV] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_d;
  end
endmodule

// File: rtl/tmr_period_fmt.sv
module tmr_period_fmt #(
  parameter int CNT_W   = 64,
  parameter int MIN_PER = 12887
) (
  input  logic             narrow,
  input  logic [CNT_W-1:0] val,
  output logic [CNT_W-1:0] period
);
  localparam int H = CNT_W / 2;
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_PER);

  logic [CNT_W-1:0] lim;

  always_comb begin
    lim = (val < MIN_V) ? MIN_V : val;
    if (narrow) period = {{(CNT_W-H+1){1'b0}}, lim[H-2:0]};
    else        period = {1'b0, lim[CNT_W-2:0]};
  end
endmodule

// File: rtl/tmr_expiry_cmp.sv
module tmr_expiry_cmp #(
  parameter int CNT_W = 64
) (
  input  logic             narrow,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  output logic             reached
);
  localparam int H = CNT_W / 2;

  logic [CNT_W-1:0] diff_w;
  logic [H-1:0]     diff_n;

  always_comb begin
    diff_w  = cnt - cmp;
    diff_n  = cnt[H-1:0] - cmp[H-1:0];
    reached = narrow ? ~diff_n[H-1] : ~diff_w[CNT_W-1];
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int MIN_PER = 12887
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glb_en,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             cmp_wr_valid,
  output logic             cmp_wr_ready,
  input  logic [CNT_W-1:0] cmp_wr_data,
  output logic [CNT_W-1:0] cmp_rdata,
  output logic             irq,
  output logic             lvl_err
);
  localparam int H = CNT_W / 2;

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cmp_q, cmp_d, per_q, per_d, per_fmt, cmp_in, cmp_sum;
  logic             adv_q, adv_d, seen_q, irq_q;
  logic             narrow, periodic, direct, cmp_acc;
  logic             reached_raw, ahead, hit, per_zero;

  assign narrow   = cfg_q[B_NAR];
  assign periodic = cfg_q[B_PER];
  assign direct   = !periodic || cfg_q[B_SV];
  assign cmp_wr_ready = !adv_q;
  assign cmp_acc  = cmp_wr_valid && cmp_wr_ready;
  assign cmp_in   = narrow ? {{(CNT_W-H){1'b0}}, cmp_wr_data[H-1:0]} : cmp_wr_data;

  tmr_cfg_reg cfg_i (
    .clk    (clk),
    .rst    (rst),
    .wr     (cfg_wr),
    .wdata  (cfg_wdata),
    .clr_sv (cmp_acc),
    .cfg_q  (cfg_q)
  );

  tmr_period_fmt #(.CNT_W(CNT_W), .MIN_PER(MIN_PER)) fmt_i (
    .narrow (narrow),
    .val    (cmp_in),
    .period (per_fmt)
  );

  tmr_expiry_cmp #(.CNT_W(CNT_W)) cmpr_i (
    .narrow  (narrow),
    .cnt     (cnt_in),
    .cmp     (cmp_q),
    .reached (reached_raw)
  );

  assign ahead    = glb_en && reached_raw;
  assign hit      = ahead && !seen_q && !adv_q;
  assign per_zero = narrow ? (per_q[H-1:0] == '0) : (per_q == '0);

  always_comb begin
    logic [H-1:0] lo_sum;
    lo_sum  = cmp_q[H-1:0] + per_q[H-1:0];
    cmp_sum = narrow ? {{(CNT_W-H){1'b0}}, lo_sum} : (cmp_q + per_q);
  end

  always_comb begin
    cmp_d = cmp_q;
    per_d = per_q;
    if (adv_q && ahead && !per_zero && !cfg_wr) cmp_d = cmp_sum;
    if (cmp_acc) begin
      if (direct) cmp_d = cmp_in;
      else        per_d = per_fmt;
    end
    if (cfg_wr && cfg_wdata[B_NAR]) begin
      cmp_d = {{(CNT_W-H){1'b0}}, cmp_d[H-1:0]};
      per_d = {{(CNT_W-H){1'b0}}, per_d[H-1:0]};
    end
    if (adv_q) adv_d = ahead && !per_zero && !cfg_wr;
    else       adv_d = hit && periodic && !per_zero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '1;
      per_q  <= '0;
      adv_q  <= 1'b0;
      seen_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      per_q  <= per_d;
      adv_q  <= adv_d;
      seen_q <= (cmp_acc && direct) ? 1'b0 : ahead;
      irq_q  <= hit && cfg_q[B_EN];
    end
  end

  assign cfg_rdata = cfg_q;
  assign cmp_rdata = cmp_q;
  assign irq       = irq_q;
  assign lvl_err   = cfg_q[B_LVL];
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             glb_en,
  input logic             cfg_wr,
  input logic [15:0]      cfg_rdata,
  input logic             cmp_wr_valid,
  input logic             cmp_wr_ready,
  input logic [CNT_W-1:0] cmp_rdata,
  input logic             irq,
  input logic             lvl_err
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cmp_rdata == '1 && cfg_rdata == '0 && !irq && cmp_wr_ready));

  assert_sv_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (cmp_wr_valid && cmp_wr_ready) |=> !cfg_rdata[6]);

  assert_advance_moves_R6: assert property (@(posedge clk) disable iff (rst)
    !cmp_wr_ready |=> (cmp_wr_ready || !$stable(cmp_rdata)));

  assert_no_irq_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !irq);

  assert_lvl_err_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(lvl_err));

  assert_busy_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(cmp_wr_ready) |-> ($past(glb_en) && $past(cfg_rdata[3])));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .glb_en       (glb_en),
  .cfg_wr       (cfg_wr),
  .cfg_rdata    (cfg_rdata),
  .cmp_wr_valid (cmp_wr_valid),
  .cmp_wr_ready (cmp_wr_ready),
  .cmp_rdata    (cmp_rdata),
  .irq          (irq),
  .lvl_err      (lvl_err)
);

// File: tb/tmr_chan_tb_top.sv
`timescale 1ns/1ps
module tmr_chan_tb_top;
  localparam int W   = 16;
  localparam int MINP = 5;
  localparam logic [15:0] C_LVL = 16'h0002, C_EN = 16'h0004, C_PER = 16'h0008,
                          C_SV  = 16'h0040, C_NAR = 16'h0100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          glb_en = 1'b0;
  logic [W-1:0]  cnt_in = '0;
  logic          cfg_wr = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [15:0]   cfg_rdata;
  logic          cmp_wr_valid = 1'b0;
  logic          cmp_wr_ready;
  logic [W-1:0]  cmp_wr_data = '0;
  logic [W-1:0]  cmp_rdata;
  logic          irq;
  logic          lvl_err;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_chan #(.CNT_W(W), .MIN_PER(MINP)) dut_i (
    .clk(clk), .rst(rst), .glb_en(glb_en), .cnt_in(cnt_in),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cmp_wr_valid(cmp_wr_valid), .cmp_wr_ready(cmp_wr_ready),
    .cmp_wr_data(cmp_wr_data), .cmp_rdata(cmp_rdata),
    .irq(irq), .lvl_err(lvl_err)
  );

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; glb_en = 1'b0; cnt_in = '0; cfg_wr = 1'b0; cmp_wr_valid = 1'b0;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  task automatic wr_cfg(logic [15:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wr_cmp(logic [W-1:0] v);
    cmp_wr_valid = 1'b1; cmp_wr_data = v;
    @(posedge clk);
    while (!cmp_wr_ready) @(posedge clk);
    @(negedge clk);
    cmp_wr_valid = 1'b0;
  endtask

  // periodic setup: comparator c, then period write v; global enable stays low
  task automatic setup_per(logic [15:0] mode, logic [W-1:0] c, logic [W-1:0] v);
    do_reset();
    wr_cfg(mode | C_PER | C_SV);
    wr_cmp(c);
    wr_cmp(v);
  endtask

  initial begin
    int base;
    int first;
    longint p, e;

    do_reset();
    // R1 reset state
    chk("R1 cmp", cmp_rdata, 16'hFFFF);
    chk("R1 cfg", cfg_rdata, 0);
    chk("R1 irq/err/ready", {irq, lvl_err, cmp_wr_ready}, 3'b001);

    // R4 entering narrow mode truncates the stored comparator
    wr_cfg(C_NAR);
    chk("R4 truncate on cfg", cmp_rdata, 16'h00FF);
    // R4 narrow write truncation; R2 one-shot direct load
    wr_cmp(16'hABCD);
    chk("R4 narrow write", cmp_rdata, 16'h00CD);
    // R8 level select flags error; unused bits read zero
    wr_cfg(16'hFFFF);
    chk("R8 lvl_err set", lvl_err, 1);
    chk("R8 cfg mask", cfg_rdata, 16'h014E);
    wr_cfg(16'h0000);
    chk("R8 lvl_err clear", lvl_err, 0);

    // R2 set-value clears on write, direct load in periodic mode
    do_reset();
    wr_cfg(C_PER | C_SV | C_EN);
    chk("R2 sv armed", cfg_rdata[6], 1);
    wr_cmp(16'd1234);
    chk("R2 sv cleared", cfg_rdata[6], 0);
    chk("R2 direct load", cmp_rdata, 16'd1234);
    wr_cmp(16'd77);
    chk("R2 period write leaves cmp", cmp_rdata, 16'd1234);

    // R3/R6 sweep of all narrow period writes
    for (int v = 0; v < 256; v++) begin
      setup_per(C_NAR | C_EN, 16'd20, 16'(v));
      base = irq_cnt;
      cnt_in = 16'd20; glb_en = 1'b1;
      step(6);
      p = ((v < MINP) ? MINP : v) & 8'h7F;
      chk("R3 narrow period", cmp_rdata, (20 + p) & 8'hFF);
      chk("R5 one pulse", irq_cnt - base, 1);
    end

    // R3 wide period writes: clamp then top-bit mask
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] v;
      v = (i < 8) ? 16'(i) : (i < 16) ? 16'(16'h8000 + i - 8) : 16'(16'h7FF0 + i);
      setup_per(C_EN, 16'd100, v);
      cnt_in = 16'd100; glb_en = 1'b1;
      step(6);
      p = ((v < MINP) ? MINP : v) & 16'h7FFF;
      chk("R3 wide period", cmp_rdata, (100 + p) & 16'hFFFF);
    end

    // R6 multi-step advance for many counter jumps; R9 busy
    for (int d = 0; d < 64; d++) begin
      setup_per(C_EN, 16'd100, 16'd7);
      cnt_in = 16'd0; glb_en = 1'b1;
      step(1);
      cnt_in = 16'(100 + d);
      step(1);
      chk("R9 ready low while advancing", cmp_wr_ready, 0);
      step(16);
      e = 100 + 7 * (d / 7 + 1);
      chk("R6 advanced cmp", cmp_rdata, e);
      chk("R9 ready back", cmp_wr_ready, 1);
    end

    // R9 write held during busy takes effect afterwards
    setup_per(C_EN, 16'd100, 16'd7);
    wr_cfg(C_EN | C_PER | C_SV);
    cnt_in = 16'd0; glb_en = 1'b1;
    step(1);
    cnt_in = 16'd170;
    step(1);
    chk("R9 busy before write", cmp_wr_ready, 0);
    wr_cmp(16'd3000);
    step(1);
    chk("R9 held write lands", cmp_rdata, 16'd3000);

    // R5 narrow one-shot sweep: fire exactly at counter == C
    for (int c = 1; c < 61; c++) begin
      do_reset();
      wr_cfg(C_NAR | C_EN);
      wr_cmp(16'(c));
      base = irq_cnt; first = -1;
      glb_en = 1'b1;
      for (int k = 0; k < c + 6; k++) begin
        cnt_in = 16'(k);
        step(1);
        if (irq && first < 0) first = k;
      end
      chk("R5 fire point", first, c);
      chk("R5 single pulse", irq_cnt - base, 1);
    end

    // R4 wrap-aware compare: narrow 200 vs 10 is before, wide is after
    do_reset();
    wr_cfg(C_NAR | C_EN);
    wr_cmp(16'd10);
    base = irq_cnt; cnt_in = 16'd200; glb_en = 1'b1;
    step(5);
    chk("R4 narrow not expired", irq_cnt - base, 0);
    do_reset();
    wr_cfg(C_EN);
    wr_cmp(16'd10);
    base = irq_cnt; cnt_in = 16'd200; glb_en = 1'b1;
    step(5);
    chk("R5 wide jump expires", irq_cnt - base, 1);
    // R5 direct rewrite to a past value re-arms
    wr_cmp(16'd50);
    step(3);
    chk("R5 rearm after write", irq_cnt - base, 2);

    // R6 narrow wrap of advanced comparator
    setup_per(C_NAR | C_EN, 16'd250, 16'd10);
    base = irq_cnt; cnt_in = 16'd250; glb_en = 1'b1;
    step(4);
    chk("R6 wrapped cmp", cmp_rdata, 16'd4);
    for (int k = 251; k < 260; k++) begin
      cnt_in = 16'(k & 8'hFF);
      step(1);
    end
    chk("R6 no early fire after wrap", irq_cnt - base, 1);
    cnt_in = 16'd4;
    step(4);
    chk("R6 fire at wrapped cmp", irq_cnt - base, 2);
    chk("R6 next cmp", cmp_rdata, 16'd14);

    // R6 zero period: no advance
    setup_per(C_NAR | C_EN, 16'd30, 16'd128);
    cnt_in = 16'd30; glb_en = 1'b1;
    step(5);
    chk("R6 zero period holds", cmp_rdata, 16'd30);

    // R7 global enable low: no fire, no advance
    setup_per(C_EN, 16'd40, 16'd9);
    base = irq_cnt; cnt_in = 16'd60;
    step(6);
    chk("R7 glb off irq", irq_cnt - base, 0);
    chk("R7 glb off cmp", cmp_rdata, 16'd40);
    // R7 timer enable low: advance without irq
    setup_per(16'h0000, 16'd40, 16'd9);
    base = irq_cnt; cnt_in = 16'd60; glb_en = 1'b1;
    step(8);
    chk("R7 tmr off irq", irq_cnt - base, 0);
    chk("R7 tmr off advance", cmp_rdata, 16'd67);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule